// File: doc/BRIEF.md
# Rail Bring-Up Sequencer with Reset Gating

This block powers up a memory expansion module in a fixed order of dependencies. It turns on one rail domain at a time and waits for that domain's power-good to be filtered and stable before it enables the next one. Index 0 is the always-on management rail, index 1 feeds the serial link, index 2 feeds the DRAM and index 3 is the high-current core rail. Each stage has a timer whose limit software sets through an input. A fault flag held by the PMIC freezes the sequence until the flag drops.

The link-side reset is released, and the device is reported ready, only when four things hold: every rail is good, the reference clock is stable, the DRAM reports that training is done and no PMIC fault is present. A loss of power-good, a protection fault, a thermal trip, a watchdog expiry or a stage timeout leads to a single orderly path. The block first asserts reset, then removes the rails from highest to lowest, and then parks in a latched safe state. It leaves that state only on an explicit clear. The block records a code for the reason it went down. It also counts the edges of each rail's filtered power-good so that the count can be read as telemetry.

Top module: `rail_sequencer`

## Requirements
- R1: Rails are enabled one at a time in index order: rail i+1 turns on only after the filtered power-good of rail i is high, and while rail i comes up the enable vector equals the mask of bits 0..i.
- R2: A raw power-good must hold a new level for DEB_CYCLES consecutive cycles, after a 2-flop synchronizer, before the filtered level follows it. Shorter glitches change no output and no edge counter.
- R3: train_permit rises only after the filtered power-good of rail 1 is high. It never rises sooner than DEB_CYCLES cycles after that rail's raw power-good rises.
- R4: dev_ready and link_rst_n are high only together, and only once all filtered power-goods are high, clk_stable and ddr_trained are high and pmic_fault is low.
- R5: While pmic_fault is high during bring-up, the sequence does not advance and the stage timer does not count. When pmic_fault drops, the sequence resumes. In the safe state, fault_clear has no effect while pmic_fault is high.
- R6: During bring-up or run, any of the following trips the block: loss of power-good on an enabled rail, pmic_fault while running, thermal_trip, wdog_expire or a stage timeout. A trip powers the rails down and then holds a latched safe state, with all rails off and reset held, whatever pwr_req does, until fault_clear arrives while pmic_fault is low.
- R7: reset_cause reads 1 after reset, 2 after a brownout or protection trip, 3 after a watchdog trip, 4 after a thermal trip and 5 after a timeout. A requested power-down leaves it unchanged.
- R8: When a stage timer reaches stage_timeout, the block trips with cause 5. timeout_stage then holds the rail index of that stage, or 4 when the stall was in the final readiness wait.
- R9: Power-down removes rails from highest to lowest, one every DN_GAP cycles. link_rst_n is low at least one cycle before the first rail turns off. When pwr_req drops, the block powers down into the off state, and it restarts when pwr_req rises again, with no clear needed.
- R10: Each rail has a CNT_W-bit counter, reset to 0, that adds one on every rising or falling edge of that rail's filtered power-good and saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | 1 | Level request to power the module up |
| pg_raw | input | NUM_RAILS | Unfiltered power-good per rail |
| pmic_fault | input | 1 | PMIC fault flag, held high by the PMIC until it is cleared |
| fault_clear | input | 1 | Pulse that releases the latched safe state |
| clk_stable | input | 1 | Reference and derived clocks are stable |
| ddr_trained | input | 1 | DRAM training is complete |
| thermal_trip | input | 1 | Thermal protection request |
| wdog_expire | input | 1 | Watchdog expiry |
| stage_timeout | input | TO_W | Timer limit for each stage, in cycles |
| rail_en | output | NUM_RAILS | Rail enables |
| link_rst_n | output | 1 | Link-side reset, active low |
| train_permit | output | 1 | Link training is allowed |
| dev_ready | output | 1 | The device is exposed to the host |
| reset_cause | output | 3 | Code for the last shutdown reason |
| timeout_stage | output | STG_W | Stage that timed out |
| pg_edge_cnt | output | NUM_RAILS*CNT_W | Edge counts of filtered power-good, one CNT_W-bit field per rail |

## Verification
The bring-up is driven with a random delay before each power-good and with the clock-stable and training-done flags held back. This separates correct ordering and gating from a sequencer that only waits for time to pass. Glitch trains shorter than the filter window are applied to a running rail, and then a held loss of power-good is applied. This separates filtering from a plain synchronizer. Thermal, watchdog, protection, timeout at a random rail and random limit, timeout in the readiness wait, and a requested power-down each end in a different cause code and exit rule. Together they show that the trip priority, the latch and the reverse-order shutdown each hold. A long toggle run in the safe state drives one counter into saturation.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_UP,
    ST_WAIT_RDY,
    ST_RUN,
    ST_PD_RST,
    ST_PD_RAIL,
    ST_SAFE
  } seq_state_t;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_POR   = 3'd1,
    CAUSE_PROT  = 3'd2,
    CAUSE_WDOG  = 3'd3,
    CAUSE_THERM = 3'd4,
    CAUSE_TMO   = 3'd5
  } cause_t;

  localparam int CAUSE_W = 3;

endpackage

// File: rtl/rseq_debounce.sv
module rseq_debounce #(
  parameter int DEB  = 8,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic good
);
  localparam int CW = $clog2(DEB + 1);

  logic [SYNC-1:0] sync_q;
  logic            synced;
  logic [CW-1:0]   cnt_q;
  logic            good_q;

  assign synced = sync_q[SYNC-1];
  assign good   = good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], raw};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else if (synced == good_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DEB - 1)) begin
      good_q <= synced;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R2
  deb_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good_q) |-> $past(synced));

  // R2
  deb_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(good_q) |-> !$past(synced));

endmodule

// File: rtl/rseq_edge_count.sv
module rseq_edge_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg,
  output logic [CNT_W-1:0] cnt
);
  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             edge_seen;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + CNT_W'(1);
  endfunction

  assign edge_seen = pg ^ prev_q;
  assign cnt       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= pg;
      if (edge_seen) cnt_q <= sat_inc(cnt_q);
    end
  end

  // R10
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(pg) || $fell(pg)) && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '1) |-> (cnt_q == '1));

endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
  import rseq_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  parameter int TO_W      = 16,
  parameter int DN_GAP    = 4,
  parameter int TRAIN_IDX = 1,
  parameter int STG_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_req,
  input  logic [NUM_RAILS-1:0] pg_good,
  input  logic                 pmic_fault,
  input  logic                 fault_clear,
  input  logic                 clk_stable,
  input  logic                 ddr_trained,
  input  logic                 thermal_trip,
  input  logic                 wdog_expire,
  input  logic [TO_W-1:0]      stage_timeout,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 link_rst_n,
  output logic                 train_permit,
  output logic                 dev_ready,
  output logic [CAUSE_W-1:0]   reset_cause,
  output logic [STG_W-1:0]     timeout_stage
);
  localparam int GAP_W = $clog2(DN_GAP + 1);

  seq_state_t           state_q;
  logic [STG_W-1:0]     stage_q;
  logic [NUM_RAILS-1:0] rails_q;
  logic [TO_W-1:0]      tmr_q;
  logic [GAP_W-1:0]     gap_q;
  cause_t               cause_q;
  logic [STG_W-1:0]     tstage_q;
  logic                 to_safe_q;

  function automatic logic [NUM_RAILS-1:0] below_mask(input logic [STG_W-1:0] idx);
    logic [NUM_RAILS-1:0] m;
    for (int i = 0; i < NUM_RAILS; i++) m[i] = (i < int'(idx));
    return m;
  endfunction

  function automatic logic [NUM_RAILS-1:0] bit_at(input logic [STG_W-1:0] idx);
    logic [NUM_RAILS-1:0] m;
    for (int i = 0; i < NUM_RAILS; i++) m[i] = (i == int'(idx));
    return m;
  endfunction

  function automatic logic [NUM_RAILS-1:0] top_bit(input logic [NUM_RAILS-1:0] v);
    logic [NUM_RAILS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_RAILS; i++) begin
      if (v[i]) begin
        m    = '0;
        m[i] = 1'b1;
      end
    end
    return m;
  endfunction

  // Named internal events
  logic                 in_up, in_wait, in_run, bringing;
  logic [NUM_RAILS-1:0] need_good;
  logic                 pg_lost;
  logic                 tmo_hit;
  logic                 step_ok;
  logic                 trip_now;
  cause_t               trip_code;
  logic                 abort_now;
  logic                 last_rail;

  assign in_up     = (state_q == ST_UP);
  assign in_wait   = (state_q == ST_WAIT_RDY);
  assign in_run    = (state_q == ST_RUN);
  assign bringing  = in_up || in_wait;
  assign last_rail = (stage_q == STG_W'(NUM_RAILS - 1));

  always_comb begin
    if (in_up)                 need_good = rails_q & below_mask(stage_q);
    else if (in_wait || in_run) need_good = rails_q;
    else                       need_good = '0;
  end

  assign pg_lost = ((pg_good & need_good) != need_good);
  assign tmo_hit = bringing && !pmic_fault && (tmr_q == stage_timeout);

  always_comb begin
    if (in_up)        step_ok = (|(pg_good & bit_at(stage_q))) && !pmic_fault;
    else if (in_wait) step_ok = clk_stable && ddr_trained && !pmic_fault;
    else              step_ok = 1'b0;
  end

  always_comb begin
    trip_now  = 1'b0;
    trip_code = CAUSE_PROT;
    if (bringing || in_run) begin
      if (pg_lost || (in_run && pmic_fault)) begin
        trip_now  = 1'b1;
        trip_code = CAUSE_PROT;
      end else if (thermal_trip) begin
        trip_now  = 1'b1;
        trip_code = CAUSE_THERM;
      end else if (wdog_expire) begin
        trip_now  = 1'b1;
        trip_code = CAUSE_WDOG;
      end else if (tmo_hit && !step_ok) begin
        trip_now  = 1'b1;
        trip_code = CAUSE_TMO;
      end
    end
  end

  assign abort_now = (bringing || in_run) && !pwr_req && !trip_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      stage_q   <= '0;
      rails_q   <= '0;
      tmr_q     <= '0;
      gap_q     <= '0;
      cause_q   <= CAUSE_POR;
      tstage_q  <= '0;
      to_safe_q <= 1'b0;
    end else begin
      case (state_q)
        ST_OFF: begin
          if (pwr_req) begin
            state_q <= ST_UP;
            stage_q <= '0;
            rails_q <= bit_at('0);
            tmr_q   <= '0;
          end
        end
        ST_UP, ST_WAIT_RDY, ST_RUN: begin
          if (trip_now) begin
            state_q   <= ST_PD_RST;
            to_safe_q <= 1'b1;
            cause_q   <= trip_code;
            if (trip_code == CAUSE_TMO) tstage_q <= stage_q;
          end else if (abort_now) begin
            state_q   <= ST_PD_RST;
            to_safe_q <= 1'b0;
          end else if (step_ok) begin
            tmr_q <= '0;
            if (in_wait) begin
              state_q <= ST_RUN;
            end else if (last_rail) begin
              state_q <= ST_WAIT_RDY;
              stage_q <= STG_W'(NUM_RAILS);
            end else begin
              stage_q <= stage_q + STG_W'(1);
              rails_q <= rails_q | bit_at(stage_q + STG_W'(1));
            end
          end else if (bringing && !pmic_fault) begin
            tmr_q <= tmr_q + TO_W'(1);
          end
        end
        ST_PD_RST: begin
          state_q <= ST_PD_RAIL;
          gap_q   <= '0;
        end
        ST_PD_RAIL: begin
          if (rails_q == '0) begin
            state_q <= to_safe_q ? ST_SAFE : ST_OFF;
          end else if (gap_q == GAP_W'(DN_GAP - 1)) begin
            rails_q <= rails_q & ~top_bit(rails_q);
            gap_q   <= '0;
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        ST_SAFE: begin
          if (fault_clear && !pmic_fault) begin
            state_q   <= ST_OFF;
            to_safe_q <= 1'b0;
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign rail_en       = rails_q;
  assign link_rst_n    = in_run;
  assign dev_ready     = in_run;
  assign train_permit  = (in_up && (stage_q > STG_W'(TRAIN_IDX))) || in_wait || in_run;
  assign reset_cause   = cause_q;
  assign timeout_stage = tstage_q;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_order_chk
    localparam logic [NUM_RAILS-1:0] LOW_M = NUM_RAILS'((1 << g) - 1);
    // R1
    rise_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rails_q[g]) |-> ((rails_q & LOW_M) == LOW_M));
    // R9
    fall_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rails_q[g]) |-> ((rails_q & ~LOW_M) == '0));
  end

  // R9
  rst_before_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rails_q) & ~rails_q) != '0) |-> (!link_rst_n && !$past(link_rst_n)));

  // R4
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_ready) |-> $past((&pg_good) && clk_stable && ddr_trained && !pmic_fault));

  // R3
  train_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_permit) |-> $past(pg_good[TRAIN_IDX]));

  // R6
  safe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAFE) |-> ((rails_q == '0) && !link_rst_n && !dev_ready));

  // R5
  fault_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bringing) && bringing && $past(pmic_fault)) |-> $stable(rails_q));

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int NUM_RAILS   = 4,
  parameter int DEB_CYCLES  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int TO_W        = 16,
  parameter int DN_GAP      = 4,
  parameter int TRAIN_IDX   = 1,
  parameter int STG_W       = $clog2(NUM_RAILS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pwr_req,
  input  logic [NUM_RAILS-1:0]       pg_raw,
  input  logic                       pmic_fault,
  input  logic                       fault_clear,
  input  logic                       clk_stable,
  input  logic                       ddr_trained,
  input  logic                       thermal_trip,
  input  logic                       wdog_expire,
  input  logic [TO_W-1:0]            stage_timeout,
  output logic [NUM_RAILS-1:0]       rail_en,
  output logic                       link_rst_n,
  output logic                       train_permit,
  output logic                       dev_ready,
  output logic [CAUSE_W-1:0]         reset_cause,
  output logic [STG_W-1:0]           timeout_stage,
  output logic [NUM_RAILS*CNT_W-1:0] pg_edge_cnt
);
  logic [NUM_RAILS-1:0] pg_good;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    rseq_debounce #(
      .DEB  (DEB_CYCLES),
      .SYNC (SYNC_STAGES)
    ) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (pg_raw[g]),
      .good  (pg_good[g])
    );

    rseq_edge_count #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .pg    (pg_good[g]),
      .cnt   (pg_edge_cnt[g*CNT_W +: CNT_W])
    );
  end

  rseq_fsm #(
    .NUM_RAILS (NUM_RAILS),
    .TO_W      (TO_W),
    .DN_GAP    (DN_GAP),
    .TRAIN_IDX (TRAIN_IDX),
    .STG_W     (STG_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_req       (pwr_req),
    .pg_good       (pg_good),
    .pmic_fault    (pmic_fault),
    .fault_clear   (fault_clear),
    .clk_stable    (clk_stable),
    .ddr_trained   (ddr_trained),
    .thermal_trip  (thermal_trip),
    .wdog_expire   (wdog_expire),
    .stage_timeout (stage_timeout),
    .rail_en       (rail_en),
    .link_rst_n    (link_rst_n),
    .train_permit  (train_permit),
    .dev_ready     (dev_ready),
    .reset_cause   (reset_cause),
    .timeout_stage (timeout_stage)
  );

endmodule

// File: tb/rail_sequencer_bench.sv
`timescale 1ns/1ps
module rail_sequencer_bench;
  localparam int N      = 4;
  localparam int DEB    = 8;
  localparam int CW     = 8;
  localparam int TW     = 16;
  localparam int GAP    = 4;
  localparam int TRAIN  = 1;
  localparam int SW     = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_req = 1'b0;
  logic [N-1:0]  pg_raw = '0;
  logic          pmic_fault = 1'b0;
  logic          fault_clear = 1'b0;
  logic          clk_stable = 1'b0;
  logic          ddr_trained = 1'b0;
  logic          thermal_trip = 1'b0;
  logic          wdog_expire = 1'b0;
  logic [TW-1:0] stage_timeout = 16'd300;
  logic [N-1:0]  rail_en;
  logic          link_rst_n;
  logic          train_permit;
  logic          dev_ready;
  logic [2:0]    reset_cause;
  logic [SW-1:0] timeout_stage;
  logic [N*CW-1:0] pg_edge_cnt;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  rail_sequencer #(
    .NUM_RAILS(N), .DEB_CYCLES(DEB), .SYNC_STAGES(2), .CNT_W(CW),
    .TO_W(TW), .DN_GAP(GAP), .TRAIN_IDX(TRAIN), .STG_W(SW)
  ) u_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .pg_raw(pg_raw),
    .pmic_fault(pmic_fault), .fault_clear(fault_clear), .clk_stable(clk_stable),
    .ddr_trained(ddr_trained), .thermal_trip(thermal_trip), .wdog_expire(wdog_expire),
    .stage_timeout(stage_timeout), .rail_en(rail_en), .link_rst_n(link_rst_n),
    .train_permit(train_permit), .dev_ready(dev_ready), .reset_cause(reset_cause),
    .timeout_stage(timeout_stage), .pg_edge_cnt(pg_edge_cnt)
  );

  // Expected-value functions taken from the requirements
  function automatic int up_mask(input int i);
    return (1 << (i + 1)) - 1;
  endfunction

  function automatic int exp_cnt(input int edges);
    return (edges > 255) ? 255 : edges;
  endfunction

  function automatic int top_of(input int v);
    int r = 0;
    for (int i = 0; i < N; i++) if (v[i]) r = 1 << i;
    return r;
  endfunction

  function automatic int cnt_of(input int r);
    return int'(pg_edge_cnt[r*CW +: CW]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear();
    fault_clear = 1'b1;
    tick(1);
    fault_clear = 1'b0;
  endtask

  // Powers rails up; stop_rail never gets power-good; block_rail sees a PMIC fault
  task automatic bring_up(input int stop_rail, input int block_rail);
    for (int i = 0; i < N; i++) begin
      bit seen = 1'b0;
      for (int c = 0; c < 400 && !seen; c++) begin
        tick(1);
        seen = rail_en[i];
      end
      chk(seen, "R1", "rail enable rises", int'(rail_en[i]), 1);
      chk(int'(rail_en) == up_mask(i), "R1", "enable mask at stage", int'(rail_en), up_mask(i));
      if (i == stop_rail) return;
      tick($urandom_range(1, 10));
      chk(int'(rail_en) == up_mask(i), "R1", "next rail waits for power-good",
          int'(rail_en), up_mask(i));
      if (i == block_rail) begin
        pmic_fault = 1'b1;
        pg_raw[i]  = 1'b1;
        tick(150);
        chk(int'(rail_en) == up_mask(i), "R5", "fault freezes sequence without timeout",
            int'(rail_en), up_mask(i));
        pmic_fault = 1'b0;
      end else begin
        pg_raw[i] = 1'b1;
      end
      if (i == TRAIN) begin
        int t = 0;
        chk(train_permit == 1'b0, "R3", "permit low at raw rise", int'(train_permit), 0);
        while (!train_permit && t < 100) begin
          tick(1);
          t++;
        end
        chk(t >= DEB && t <= DEB + 6, "R3", "permit delay after raw rise", t, DEB + 3);
      end
    end
  endtask

  task automatic wait_ready(input string req);
    int t = 0;
    while (!dev_ready && t < 100) begin
      tick(1);
      t++;
    end
    chk(dev_ready && link_rst_n, req, "device ready and reset released", int'(dev_ready), 1);
  endtask

  // Follows rails down; pg_raw mirrors the enables; checks order and reset lead
  task automatic wait_off(output int cycles);
    int prev_en;
    bit prev_rst;
    int bad = 0;
    int drops = 0;
    prev_en  = int'(rail_en);
    prev_rst = link_rst_n;
    cycles   = 0;
    while ((rail_en != '0 || cycles == 0) && cycles < 2000) begin
      tick(1);
      cycles++;
      pg_raw = pg_raw & rail_en;
      if ((prev_en & ~int'(rail_en)) != 0) begin
        drops++;
        if (drops == 1) cycles = -cycles;
        if (prev_rst || link_rst_n) bad++;
        if ((prev_en & ~int'(rail_en)) != top_of(prev_en)) bad++;
      end
      prev_en  = int'(rail_en);
      prev_rst = link_rst_n;
    end
    chk(bad == 0, "R9", "reverse order with reset first", bad, 0);
    chk(rail_en == '0, "R9", "all rails off", int'(rail_en), 0);
    if (cycles < 0) cycles = -cycles;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    bit ready_kept;
    void'($urandom(32'h5eed_0417));

    tick(5);
    chk(rail_en == '0, "R1", "reset rails off", int'(rail_en), 0);
    chk(!link_rst_n && !dev_ready, "R4", "reset holds link", int'(link_rst_n), 0);
    chk(!train_permit, "R3", "reset permit low", int'(train_permit), 0);
    chk(reset_cause == 3'd1, "R7", "power-on cause", int'(reset_cause), 1);
    chk(pg_edge_cnt == '0, "R10", "counters cleared", int'(pg_edge_cnt[CW-1:0]), 0);
    rst_n = 1'b1;
    tick(3);

    // Bring-up with readiness flags held back
    pwr_req = 1'b1;
    bring_up(-1, -1);
    tick(40);
    chk(!dev_ready && !link_rst_n, "R4", "no exposure without clock/training",
        int'(dev_ready), 0);
    clk_stable = 1'b1;
    tick(20);
    chk(!dev_ready && !link_rst_n, "R4", "no exposure without training", int'(dev_ready), 0);
    ddr_trained = 1'b1;
    wait_ready("R4");
    for (int r = 0; r < N; r++)
      chk(cnt_of(r) == exp_cnt(1), "R10", "one edge per rail", cnt_of(r), exp_cnt(1));

    // Random glitch trains shorter than the filter window
    ready_kept = 1'b1;
    for (int p = 0; p < 30; p++) begin
      int k = $urandom_range(0, N - 1);
      int len = $urandom_range(1, DEB - 2);
      pg_raw[k] = 1'b0;
      for (int c = 0; c < len; c++) begin
        tick(1);
        if (!dev_ready) ready_kept = 1'b0;
      end
      pg_raw[k] = 1'b1;
      for (int c = 0; c < int'($urandom_range(DEB, DEB + 4)); c++) begin
        tick(1);
        if (!dev_ready) ready_kept = 1'b0;
      end
    end
    chk(ready_kept, "R2", "glitches leave device ready", int'(ready_kept), 1);
    for (int r = 0; r < N; r++)
      chk(cnt_of(r) == exp_cnt(1), "R2", "glitches not counted", cnt_of(r), exp_cnt(1));

    // Held brownout on the DRAM rail
    pg_raw[2] = 1'b0;
    wait_off(cyc);
    chk(reset_cause == 3'd2, "R7", "brownout cause", int'(reset_cause), 2);
    tick(60);
    chk(rail_en == '0 && !link_rst_n, "R6", "safe state latched under pwr_req", int'(rail_en), 0);
    for (int r = 0; r < N; r++)
      chk(cnt_of(r) == exp_cnt(2), "R10", "rise and fall counted", cnt_of(r), exp_cnt(2));

    // Clear ignored while fault held; bring-up blocked by fault mid-way
    pmic_fault = 1'b1;
    pulse_clear();
    tick(20);
    chk(rail_en == '0, "R5", "clear ignored under fault", int'(rail_en), 0);
    pmic_fault = 1'b0;
    stage_timeout = 16'd40;
    pulse_clear();
    bring_up(-1, 2);
    wait_ready("R5");
    stage_timeout = 16'd300;

    // Thermal trip
    thermal_trip = 1'b1;
    wait_off(cyc);
    chk(reset_cause == 3'd4, "R7", "thermal cause", int'(reset_cause), 4);
    thermal_trip = 1'b0;
    tick(30);
    pulse_clear();
    bring_up(-1, -1);
    wait_ready("R6");

    // Watchdog pulse
    wdog_expire = 1'b1;
    tick(1);
    wdog_expire = 1'b0;
    wait_off(cyc);
    chk(reset_cause == 3'd3, "R7", "watchdog cause", int'(reset_cause), 3);
    tick(30);
    pulse_clear();
    bring_up(-1, -1);
    wait_ready("R6");

    // Protection fault while running
    pmic_fault = 1'b1;
    tick(1);
    pmic_fault = 1'b0;
    wait_off(cyc);
    chk(reset_cause == 3'd2, "R6", "fault in run trips", int'(reset_cause), 2);
    tick(30);
    pulse_clear();
    bring_up(-1, -1);
    wait_ready("R6");

    // Requested power-down and restart without clear
    pwr_req = 1'b0;
    wait_off(cyc);
    chk(reset_cause == 3'd2, "R7", "requested off keeps cause", int'(reset_cause), 2);
    tick(30);
    chk(rail_en == '0, "R9", "stays off without request", int'(rail_en), 0);
    pwr_req = 1'b1;
    bring_up(-1, -1);
    wait_ready("R9");

    // Timeouts at random rails and limits
    for (int it = 0; it < 3; it++) begin
      int stop = $urandom_range(0, N - 1);
      int lim = $urandom_range(20, 80);
      pwr_req = 1'b0;
      wait_off(cyc);
      tick(20);
      stage_timeout = TW'(lim);
      pwr_req = 1'b1;
      bring_up(stop, -1);
      wait_off(cyc);
      chk(reset_cause == 3'd5, "R8", "timeout cause", int'(reset_cause), 5);
      chk(int'(timeout_stage) == stop, "R8", "timed-out stage", int'(timeout_stage), stop);
      chk(cyc >= lim && cyc <= lim + GAP + 6, "R8", "timeout latency", cyc, lim + GAP + 2);
      tick(20);
      pulse_clear();
    end

    // Timeout in readiness wait
    stage_timeout = 16'd60;
    clk_stable = 1'b0;
    bring_up(-1, -1);
    wait_off(cyc);
    chk(int'(timeout_stage) == 4 && reset_cause == 3'd5, "R8", "readiness wait stage",
        int'(timeout_stage), 4);

    // Counter saturation while parked in safe state
    for (int e = 0; e < 270; e++) begin
      pg_raw[0] = ~pg_raw[0];
      tick(DEB + 4);
    end
    chk(cnt_of(0) == exp_cnt(270), "R10", "counter saturates", cnt_of(0), exp_cnt(270));
    chk(rail_en == '0, "R6", "safe state ignores power-good", int'(rail_en), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule